// File: doc/BRIEF.md
# Stream-to-Memory Descriptor Walker

This block takes a byte-wide frame from a stream input and scatters it into memory buffers. The buffers are described by a linked list of descriptors. For each descriptor the walker reads four words from memory: the link to the next descriptor, the buffer address, the capacity and the status. It then fills the buffer, writes a status word back and follows the link. The descriptor that opens a frame is marked as the start. The descriptor that takes the final byte is marked as the end and also receives five application words, which arrive separately on a control input.

Software prepares the chain and points the channel at its head with a start strobe. It bounds the walk by writing a tail address. When the walker has handled the descriptor at the tail, it goes idle. A later tail write wakes it, and the same frame continues. If the walker meets a descriptor whose done bit is already set, the channel halts until the next start strobe. A one-cycle pulse marks each frame that has been fully written back.

Top module: `frame_scatter_walker`

## Requirements
- R1: After reset, `stHalted` is 1, `stIdle` is 0, `sReady` is 0, `frameDone` is 0, `appReady` is 1, and no memory write is issued.
- R2: `sReady` is high only while `runEnable` is 1 and both idle and halted are clear. While `runEnable` is 0, no stream byte is taken.
- R3: Descriptor word layout, as word offsets from the descriptor address: 0 is the next link, 1 the buffer address, 2 the capacity in bytes (bits 22:0), 3 the status. If a loaded status has bit 31 set, `stHalted` goes to 1. Nothing is written, and no byte is accepted, until `chanStart`. `chanStart` clears halted and idle.
- R4: Byte k held by a descriptor is stored at buffer address + k. Each byte is a single write with one byte enable, `memBe` bit = address[1:0], and the data is placed in that lane. A descriptor takes at most its capacity. The rest of the frame goes on into the next descriptor. A frame that ends exactly at capacity ends in that descriptor.
- R5: Every descriptor used gets its status word written with bit 31 set and bits 22:0 equal to the number of bytes it stored. Bits 30:28 and 25:23 are zero.
- R6: Status bit 27 is set only in the first descriptor of a frame.
- R7: The descriptor that takes the final byte (the one with `sLast`) gets status bit 26 and the five application words at word offsets 4 to 8. Other descriptors keep their offsets 4 to 8 unchanged.
- R8: `frameDone` pulses for exactly one cycle per frame, after all write-backs for that frame.
- R9: After the descriptor at the tail address is written back, `stIdle` goes to 1 and `sReady` stays 0. A tail write clears idle. The unfinished frame then continues in the next descriptor, without the start mark.
- R10: The control input takes five words per frame, in order, accepted on `appValid && appReady`. They land in arrival order at offsets 4 to 8. `appReady` is low only while those words are being written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEnable | input | 1 | Channel run level |
| chanStart | input | 1 | Load head address, clear halted and idle (honoured between descriptors) |
| headAddr | input | AW | First descriptor address |
| tailWrite | input | 1 | Tail update strobe, clears idle |
| tailAddr | input | AW | Last descriptor the walker may handle |
| sValid | input | 1 | Stream byte valid |
| sData | input | 8 | Stream byte |
| sLast | input | 1 | Final byte of frame |
| sReady | output | 1 | Stream byte accepted when high with sValid |
| appValid | input | 1 | Control word valid |
| appData | input | 32 | Control word |
| appReady | output | 1 | Control word accepted when high with appValid |
| memRd | output | 1 | Word read request, data returned next cycle |
| memWr | output | 1 | Write request |
| memAddr | output | AW | Byte address |
| memBe | output | 4 | Byte enables |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after memRd |
| stIdle | output | 1 | Tail reached |
| stHalted | output | 1 | Halted (reset or done descriptor found) |
| frameDone | output | 1 | One-cycle frame-complete pulse |

## Verification
A wrong byte count shows up in the status word written at the end of that same descriptor. It also shows up in the buffer address of the next byte, as a shifted lane or a byte spilled past capacity, within one accepted byte. A stale start/end flag shows up in the next status write-back. A bad link or a bad tail compare shows up as an early or missing idle and writes at the wrong descriptor, within the following read of four words. Any path that opens `sReady` while idle or halted is caught on the cycle it happens.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int LEN_W      = 23;
  localparam int APP_WORDS  = 5;
  localparam int APP_IDX_W  = $clog2(APP_WORDS);
  localparam int STAT_OFS   = 12;
  localparam int APP_OFS    = 16;

  typedef enum logic [2:0] {
    S_WAIT, S_LOAD, S_SETTLE, S_CHECK, S_XFER, S_WBSTAT, S_WBAPP, S_ADV
  } walkState_t;

  typedef struct packed {
    logic                 rdEn;
    logic [1:0]           rdIdx;
    logic                 byteWr;
    logic                 statWr;
    logic                 appWr;
    logic [APP_IDX_W-1:0] appIdx;
    logic                 sofMark;
    logic                 eofMark;
    logic                 advance;
    logic                 loadHead;
    logic                 appOpen;
  } walkStrobe_t;
endpackage

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
  import fsw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEnable,
  input  logic        chanStart,
  input  logic        tailWrite,
  input  logic        sValid,
  input  logic        sLast,
  input  logic        lenReached,
  input  logic        lastSlot,
  input  logic        descOwned,
  input  logic        atTail,
  output walkStrobe_t strb,
  output logic        sReady,
  output logic        appReady,
  output logic        stIdle,
  output logic        stHalted,
  output logic        frameDone
);
  walkState_t state, stateNx;
  logic [1:0] ldCnt;
  logic [APP_IDX_W-1:0] appCnt;
  logic sofQ, eofQ, idleQ, haltQ;
  logic canRun, accept;

  always_comb begin
    canRun        = runEnable && !idleQ && !haltQ;
    sReady        = (state == S_XFER) && runEnable && !lenReached;
    accept        = sReady && sValid;
    strb          = '0;
    strb.rdIdx    = ldCnt;
    strb.appIdx   = appCnt;
    strb.sofMark  = sofQ;
    strb.eofMark  = eofQ;
    strb.appOpen  = (state != S_WBAPP);
    frameDone     = 1'b0;
    stateNx       = state;
    unique case (state)
      S_WAIT: begin
        strb.loadHead = chanStart;
        if (!chanStart && canRun && sValid) stateNx = S_LOAD;
      end
      S_LOAD: begin
        strb.rdEn = 1'b1;
        if (ldCnt == 2'd3) stateNx = S_SETTLE;
      end
      S_SETTLE: stateNx = S_CHECK;
      S_CHECK:  stateNx = descOwned ? S_WAIT : S_XFER;
      S_XFER: begin
        strb.byteWr = accept;
        if (accept && (sLast || lastSlot)) stateNx = S_WBSTAT;
        else if (lenReached)               stateNx = S_WBSTAT;
      end
      S_WBSTAT: begin
        strb.statWr = 1'b1;
        stateNx = eofQ ? S_WBAPP : S_ADV;
      end
      S_WBAPP: begin
        strb.appWr = 1'b1;
        if (appCnt == APP_IDX_W'(APP_WORDS - 1)) stateNx = S_ADV;
      end
      S_ADV: begin
        strb.advance = 1'b1;
        frameDone    = eofQ;
        stateNx      = (atTail || eofQ) ? S_WAIT : S_LOAD;
      end
      default: stateNx = S_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_WAIT;
      ldCnt <= '0;
      appCnt <= '0;
      sofQ <= 1'b1;
      eofQ <= 1'b0;
      idleQ <= 1'b0;
      haltQ <= 1'b1;
    end else begin
      state  <= stateNx;
      ldCnt  <= (state == S_LOAD) ? ldCnt + 2'd1 : 2'd0;
      appCnt <= (state == S_WBAPP) ? appCnt + 1'b1 : '0;
      if (state == S_XFER && accept && sLast) eofQ <= 1'b1;
      if (state == S_ADV) begin
        sofQ <= eofQ;
        eofQ <= 1'b0;
      end
      if (state == S_CHECK && descOwned) haltQ <= 1'b1;
      if (state == S_WAIT && chanStart)  haltQ <= 1'b0;
      if (state == S_ADV && atTail)      idleQ <= 1'b1;
      if ((state == S_WAIT && chanStart) || tailWrite) idleQ <= 1'b0;
    end
  end

  assign appReady = strb.appOpen;
  assign stIdle   = idleQ;
  assign stHalted = haltQ;
endmodule

// File: rtl/fsw_datapath.sv
module fsw_datapath
  import fsw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  walkStrobe_t   strb,
  input  logic [AW-1:0] headAddr,
  input  logic          tailWrite,
  input  logic [AW-1:0] tailAddr,
  input  logic [7:0]    sData,
  input  logic          appValid,
  input  logic [31:0]   appData,
  input  logic [31:0]   memRdata,
  output logic          memRd,
  output logic          memWr,
  output logic [AW-1:0] memAddr,
  output logic [3:0]    memBe,
  output logic [31:0]   memWdata,
  output logic          lenReached,
  output logic          lastSlot,
  output logic          descOwned,
  output logic          atTail
);
  logic [AW-1:0] curDesc, tailPtr, nextPtr, bufPtr, byteAddr;
  logic [LEN_W-1:0] descLen, byteCnt;
  logic ownedQ, rdPend;
  logic [1:0] rdIdxQ;
  logic [APP_IDX_W-1:0] appWrIdx;
  logic [31:0] appWords [APP_WORDS];
  logic unusedHighBits;

  assign unusedHighBits = ^memRdata[30:LEN_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc <= '0;
      tailPtr <= '0;
      nextPtr <= '0;
      bufPtr  <= '0;
      descLen <= '0;
      ownedQ  <= 1'b0;
      rdPend  <= 1'b0;
      rdIdxQ  <= '0;
      byteCnt <= '0;
    end else begin
      if (strb.loadHead)     curDesc <= headAddr;
      else if (strb.advance) curDesc <= nextPtr;
      if (tailWrite) tailPtr <= tailAddr;
      rdPend <= strb.rdEn;
      rdIdxQ <= strb.rdIdx;
      if (rdPend) begin
        unique case (rdIdxQ)
          2'd0: nextPtr <= memRdata[AW-1:0];
          2'd1: bufPtr  <= memRdata[AW-1:0];
          2'd2: descLen <= memRdata[LEN_W-1:0];
          default: ownedQ <= memRdata[31];
        endcase
      end
      if (strb.advance)     byteCnt <= '0;
      else if (strb.byteWr) byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) appWrIdx <= '0;
    else if (appValid && strb.appOpen)
      appWrIdx <= (appWrIdx == APP_IDX_W'(APP_WORDS - 1)) ? '0 : appWrIdx + 1'b1;
  end

  for (genvar g = 0; g < APP_WORDS; g++) begin : gAppSlot
    logic [31:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) slotQ <= '0;
      else if (appValid && strb.appOpen && appWrIdx == APP_IDX_W'(g)) slotQ <= appData;
    end
    assign appWords[g] = slotQ;
  end

  always_comb begin
    byteAddr = bufPtr + AW'(byteCnt);
    memRd    = strb.rdEn;
    memWr    = strb.byteWr | strb.statWr | strb.appWr;
    memAddr  = curDesc + AW'({strb.rdIdx, 2'b00});
    memBe    = 4'hF;
    memWdata = '0;
    if (strb.byteWr) begin
      memAddr  = byteAddr;
      memBe    = 4'b0001 << byteAddr[1:0];
      memWdata = {4{sData}};
    end else if (strb.statWr) begin
      memAddr  = curDesc + AW'(STAT_OFS);
      memWdata = {1'b1, 3'b000, strb.sofMark, strb.eofMark, 3'b000, byteCnt};
    end else if (strb.appWr) begin
      memAddr  = curDesc + AW'(APP_OFS) + AW'({strb.appIdx, 2'b00});
      memWdata = appWords[strb.appIdx];
    end
  end

  assign lenReached = (byteCnt == descLen);
  assign lastSlot   = ({1'b0, byteCnt} + 1'b1) == {1'b0, descLen};
  assign descOwned  = ownedQ;
  assign atTail     = (curDesc == tailPtr);
endmodule

// File: rtl/frame_scatter_walker.sv
module frame_scatter_walker
  import fsw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEnable,
  input  logic          chanStart,
  input  logic [AW-1:0] headAddr,
  input  logic          tailWrite,
  input  logic [AW-1:0] tailAddr,
  input  logic          sValid,
  input  logic [7:0]    sData,
  input  logic          sLast,
  output logic          sReady,
  input  logic          appValid,
  input  logic [31:0]   appData,
  output logic          appReady,
  output logic          memRd,
  output logic          memWr,
  output logic [AW-1:0] memAddr,
  output logic [3:0]    memBe,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          stIdle,
  output logic          stHalted,
  output logic          frameDone
);
  walkStrobe_t strb;
  logic lenReached, lastSlot, descOwned, atTail;

  fsw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .runEnable(runEnable), .chanStart(chanStart),
    .tailWrite(tailWrite), .sValid(sValid), .sLast(sLast),
    .lenReached(lenReached), .lastSlot(lastSlot), .descOwned(descOwned),
    .atTail(atTail), .strb(strb), .sReady(sReady), .appReady(appReady),
    .stIdle(stIdle), .stHalted(stHalted), .frameDone(frameDone)
  );

  fsw_datapath #(.AW(AW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .headAddr(headAddr),
    .tailWrite(tailWrite), .tailAddr(tailAddr), .sData(sData),
    .appValid(appValid), .appData(appData), .memRdata(memRdata),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .lenReached(lenReached), .lastSlot(lastSlot),
    .descOwned(descOwned), .atTail(atTail)
  );
endmodule

// File: rtl/frame_scatter_walker_chk.sv
module frame_scatter_walker_chk (
  input logic       clk,
  input logic       rstN,
  input logic       runEnable,
  input logic       sReady,
  input logic       stIdle,
  input logic       stHalted,
  input logic       frameDone,
  input logic       memWr,
  input logic [3:0] memBe
);
  a_r2_ready_gate: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> (runEnable && !stIdle && !stHalted));

  a_r3_halt_no_write: assert property (@(posedge clk) disable iff (!rstN)
    stHalted |-> !memWr);

  a_r4_lane_select: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> ($countones(memBe) == 1 || memBe == 4'hF));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    stIdle |-> (!memWr && !sReady));
endmodule

bind frame_scatter_walker frame_scatter_walker_chk uChk (
  .clk(clk), .rstN(rstN), .runEnable(runEnable), .sReady(sReady),
  .stIdle(stIdle), .stHalted(stHalted), .frameDone(frameDone),
  .memWr(memWr), .memBe(memBe)
);

// File: tb/frame_scatter_walker_test.sv
module frame_scatter_walker_test;
  logic clk = 0, rstN = 0;
  logic runEnable = 1, chanStart = 0, tailWrite = 0;
  logic [31:0] headAddr = 0, tailAddr = 0;
  logic sValid = 0, sLast = 0;
  logic [7:0] sData = 0;
  logic appValid = 0;
  logic [31:0] appData = 0;
  logic sReady, appReady, memRd, memWr, stIdle, stHalted, frameDone;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0] memBe;
  logic [31:0] mem [0:1023];
  int tests = 0, fails = 0, frameCount = 0, cycles = 0;

  always #10 clk = ~clk;

  frame_scatter_walker uut (.*);

  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr[11:2]];
    if (memWr)
      for (int l = 0; l < 4; l++)
        if (memBe[l]) mem[memAddr[11:2]][8*l +: 8] <= memWdata[8*l +: 8];
  end

  always @(negedge clk) if (frameDone) frameCount++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdWord(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  function automatic logic [7:0] rdByte(input logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  task automatic putDesc(input logic [31:0] a, nxt, buff, len, stat);
    mem[a[11:2]]     = nxt;
    mem[a[11:2] + 1] = buff;
    mem[a[11:2] + 2] = len;
    mem[a[11:2] + 3] = stat;
    for (int k = 0; k < 5; k++) mem[a[11:2] + 4 + k] = 32'hDEAD0000 + k;
  endtask

  task automatic startChan(input logic [31:0] head, tail);
    @(negedge clk);
    headAddr = head; chanStart = 1; tailAddr = tail; tailWrite = 1;
    @(negedge clk);
    chanStart = 0; tailWrite = 0;
  endtask

  task automatic setTail(input logic [31:0] tail);
    @(negedge clk);
    tailAddr = tail; tailWrite = 1;
    @(negedge clk);
    tailWrite = 0;
  endtask

  task automatic sendApp(input logic [31:0] base);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      appValid = 1; appData = base + k;
      while (!appReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    appValid = 0;
  endtask

  task automatic sendFrame(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sValid = 1; sData = base + 8'(i); sLast = (i == n - 1);
      while (!sReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    sValid = 0; sLast = 0;
  endtask

  task automatic waitFrames(input int target);
    while (frameCount < target) @(posedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset;
    @(negedge clk);
    chk("R1 halted", 32'(stHalted), 1);
    chk("R1 idle", 32'(stIdle), 0);
    chk("R1 ready", 32'(sReady), 0);
    chk("R1 frameDone", 32'(frameDone), 0);
    chk("R1 appReady", 32'(appReady), 1);
    chk("R1 no write", 32'(memWr), 0);
  endtask

  task automatic testSingle;
    putDesc(32'h100, 32'h140, 32'h401, 32'd8, 32'h0);
    startChan(32'h100, 32'h100);
    chk("R3 start clears halted", 32'(stHalted), 0);
    sendApp(32'h11110000);
    sendFrame(5, 8'h30);
    waitFrames(1);
    chk("R5 R6 R7 single status", rdWord(32'h10C), 32'h8C000005);
    for (int k = 0; k < 5; k++)
      chk("R7 R10 app word", rdWord(32'h110 + 4*k), 32'h11110000 + k);
    for (int i = 0; i < 5; i++)
      chk("R4 byte lane", 32'(rdByte(32'h401 + i)), 32'h30 + i);
    chk("R4 byte before buffer", 32'(rdByte(32'h400)), 0);
    chk("R4 byte after frame", 32'(rdByte(32'h406)), 0);
    chk("R9 idle at tail", 32'(stIdle), 1);
    chk("R9 ready low idle", 32'(sReady), 0);
    chk("R8 one frame", 32'(frameCount), 1);
  endtask

  task automatic testChain;
    putDesc(32'h200, 32'h240, 32'h500, 32'd4, 32'h0);
    putDesc(32'h240, 32'h280, 32'h520, 32'd4, 32'h0);
    putDesc(32'h280, 32'h2C0, 32'h540, 32'd8, 32'h0);
    startChan(32'h200, 32'h280);
    sendApp(32'h22220000);
    sendFrame(10, 8'h50);
    waitFrames(2);
    chk("R5 R6 first status", rdWord(32'h20C), 32'h88000004);
    chk("R6 middle status", rdWord(32'h24C), 32'h80000004);
    chk("R7 last status", rdWord(32'h28C), 32'h84000002);
    chk("R7 first app untouched", rdWord(32'h210), 32'hDEAD0000);
    chk("R7 middle app untouched", rdWord(32'h260), 32'hDEAD0004);
    for (int k = 0; k < 5; k++)
      chk("R10 second frame app", rdWord(32'h290 + 4*k), 32'h22220000 + k);
    for (int i = 0; i < 4; i++) begin
      chk("R4 spill d0", 32'(rdByte(32'h500 + i)), 32'h50 + i);
      chk("R4 spill d1", 32'(rdByte(32'h520 + i)), 32'h54 + i);
    end
    chk("R4 spill d2 b0", 32'(rdByte(32'h540)), 32'h58);
    chk("R4 spill d2 b1", 32'(rdByte(32'h541)), 32'h59);
    chk("R8 two frames", 32'(frameCount), 2);
  endtask

  task automatic testIdleResume;
    int seenReady;
    putDesc(32'h300, 32'h340, 32'h600, 32'd4, 32'h0);
    putDesc(32'h340, 32'h380, 32'h620, 32'd8, 32'h0);
    @(negedge clk); runEnable = 0;
    startChan(32'h300, 32'h300);
    sendApp(32'h33330000);
    seenReady = 0;
    fork
      sendFrame(6, 8'h70);
      begin
        repeat (12) begin @(negedge clk); if (sReady) seenReady++; end
        chk("R2 no ready while run low", 32'(seenReady), 0);
        runEnable = 1;
        while (!stIdle) @(negedge clk);
        seenReady = 0;
        repeat (6) begin @(negedge clk); if (sReady) seenReady++; end
        chk("R9 ready low while idle", 32'(seenReady), 0);
        chk("R9 tail descriptor status", rdWord(32'h30C), 32'h88000004);
        chk("R8 no pulse mid frame", 32'(frameCount), 2);
        setTail(32'h340);
      end
    join
    waitFrames(3);
    chk("R9 resumed without start mark", rdWord(32'h34C), 32'h84000002);
    chk("R9 resumed byte 4", 32'(rdByte(32'h620)), 32'h74);
    chk("R9 resumed byte 5", 32'(rdByte(32'h621)), 32'h75);
    chk("R10 third frame app", rdWord(32'h350), 32'h33330000);
    chk("R10 third frame app last", rdWord(32'h360), 32'h33330004);
  endtask

  task automatic testOwnedAndExact;
    int seenReady;
    putDesc(32'h3C0, 32'h800, 32'h700, 32'd4, 32'h80000000);
    startChan(32'h3C0, 32'h3C0);
    @(negedge clk);
    sValid = 1; sData = 8'h99; sLast = 1;
    seenReady = 0;
    repeat (20) begin @(negedge clk); if (sReady) seenReady++; end
    sValid = 0; sLast = 0;
    chk("R3 halted on done descriptor", 32'(stHalted), 1);
    chk("R3 no byte accepted", 32'(seenReady), 0);
    chk("R3 status untouched", rdWord(32'h3CC), 32'h80000000);
    chk("R3 buffer untouched", 32'(rdByte(32'h700)), 0);
    chk("R3 no pulse", 32'(frameCount), 3);
    mem[32'h3CC >> 2] = 32'h0;
    startChan(32'h3C0, 32'h3C0);
    chk("R3 restart clears halted", 32'(stHalted), 0);
    sendApp(32'h44440000);
    sendFrame(4, 8'h90);
    waitFrames(4);
    chk("R4 exact fit status", rdWord(32'h3CC), 32'h8C000004);
    chk("R4 exact fit last byte", 32'(rdByte(32'h703)), 32'h93);
    chk("R7 exact fit app", rdWord(32'h3D0), 32'h44440000);
    chk("R8 four frames", 32'(frameCount), 4);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSingle();
    testChain();
    testIdleResume();
    testOwnedAndExact();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule